// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits beside the fetch stage and guesses where control flow goes next. Each cycle the fetch stage presents an instruction address. The block answers in the same cycle with three things: whether the address is held in a small direct-mapped target buffer, the predicted direction, and the stored destination. Only three kinds of direct branch are ever held in the buffer: the plain jump and the call in the 32-bit instruction set, and the plain jump in the 16-bit instruction set.

When a branch resolves, the execute stage sends back the following: the branch address, its class, whether it was taken, where it really went, and which instruction-set mode it ran in. In that same cycle the block reports whether its earlier guess was wrong and how many penalty cycles the pipeline must pay. At the next clock edge it updates the buffer entry: the 2-bit direction counter, the stored destination, or a new allocation. Instructions that load the program counter any other way are never predicted, and they always pay the penalty.

Top module: `btb_predictor`

## Requirements
- R1: `rs_class` encodes 0 = 32-bit jump, 1 = 32-bit call, 2 = 16-bit jump and 3 = any other write to the program counter. Only classes 0 to 2 are eligible for prediction or allocation.
- R2: A class 3 resolution always reports a misprediction with the penalty for its mode, and it never creates a buffer entry: a lookup of that address afterwards misses.
- R3: An eligible branch that misses the buffer allocates an entry only when it resolves taken. A not-taken miss leaves the buffer unchanged.
- R4: A lookup that misses gives `lk_hit`=0 and `lk_taken`=0. A hit gives the stored target on `lk_target`.
- R5: Each entry keeps a 2-bit saturating counter. A new entry starts at 2 (weakly taken). The prediction is taken when bit 1 is set. A taken outcome increments the counter up to 3 and a not-taken outcome decrements it down to 0.
- R6: A misprediction is reported in three cases: a hit predicted not taken that resolves taken, a miss that resolves taken, and a hit predicted taken that resolves not taken.
- R7: `rs_penalty` is 0 for a correct prediction. On a misprediction it is 4 when `rs_narrow`=0 and 5 when `rs_narrow`=1.
- R8: A hit predicted taken that resolves taken to a different target counts as a misprediction, and the stored target is replaced by the actual one.
- R9: The index is address bits [8:2]. The tag is address bits [31:9] together with bit 1. A taken branch that misses on a valid entry with another tag replaces that entry.
- R10: A synchronous reset clears every entry, so every lookup misses afterwards.
- R11: When a lookup and an update hit the same index in one cycle, the lookup returns the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Address is held in the buffer |
| lk_taken | output | 1 | Predicted direction |
| lk_target | output | 32 | Predicted destination (0 on a miss) |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolving instruction |
| rs_class | input | 2 | Instruction class (see R1) |
| rs_taken | input | 1 | Actual outcome |
| rs_target | input | 32 | Actual destination |
| rs_narrow | input | 1 | 1 for 16-bit mode, 0 for 32-bit mode |
| rs_mispredict | output | 1 | Prediction was wrong |
| rs_penalty | output | 3 | Penalty cycles for this resolution |

## Verification
The bench uses the default parameters: 128 entries, 32-bit addresses, and penalties of 4 and 5. These values let it reach every counter state, and the fixed index and tag split lets it build addresses that alias. The random phase draws from a small pool of branch addresses spaced 512 bytes apart, both halfword offsets included, and this forces tag conflicts and replacement (R9). Directed steps reach each misprediction case, the counter limits, a target change, a same-cycle collision and a reset in the middle of the run.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;
  typedef enum logic [1:0] {
    BR_WIDE_JMP   = 2'd0,
    BR_WIDE_CALL  = 2'd1,
    BR_NARROW_JMP = 2'd2,
    BR_PC_WRITE   = 2'd3
  } br_class_e;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

  // R1: only direct branches take part in prediction
  function automatic logic class_eligible(input br_class_e c);
    return c != BR_PC_WRITE;
  endfunction

  // R5: saturating 2-bit direction counter
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input logic [1:0] c);
    return c[1];
  endfunction
endpackage

// File: rtl/btb_store.sv
`timescale 1ns/1ps
module btb_store #(
  parameter int ENTRIES = 128,
  parameter int TAG_W   = 24,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic              rd0_valid,
  output logic [TAG_W-1:0]  rd0_tag,
  output logic [ADDR_W-1:0] rd0_tgt,
  output logic [1:0]        rd0_ctr,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic              rd1_valid,
  output logic [TAG_W-1:0]  rd1_tag,
  output logic [ADDR_W-1:0] rd1_tgt,
  output logic [1:0]        rd1_ctr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic [1:0]        wr_ctr
);
  logic              valid_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [ADDR_W-1:0] tgt_q   [ENTRIES];
  logic [1:0]        ctr_q   [ENTRIES];

  // R10: valid bits are cleared by the synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  // R11: reads are combinational, so a same-cycle write is seen only next cycle
  always_comb begin
    rd0_valid = valid_q[rd0_idx];
    rd0_tag   = tag_q[rd0_idx];
    rd0_tgt   = tgt_q[rd0_idx];
    rd0_ctr   = ctr_q[rd0_idx];
    rd1_valid = valid_q[rd1_idx];
    rd1_tag   = tag_q[rd1_idx];
    rd1_tgt   = tgt_q[rd1_idx];
    rd1_ctr   = ctr_q[rd1_idx];
  end
endmodule

// File: rtl/btb_resolve.sv
`timescale 1ns/1ps
module btb_resolve
  import btb_pkg::*;
#(
  parameter int TAG_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              rs_valid,
  input  br_class_e         cls,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  input  logic [TAG_W-1:0]  tag,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_tgt,
  input  logic [1:0]        ent_ctr,
  output logic              hit,
  output logic              pred_taken,
  output logic              tgt_wrong,
  output logic              mispredict,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_tgt,
  output logic [1:0]        wr_ctr
);
  logic elig;

  always_comb begin
    elig       = class_eligible(cls);
    hit        = elig && ent_valid && (ent_tag == tag);
    pred_taken = hit && ctr_says_taken(ent_ctr);
    // R8: a taken branch to a new place is a miss in disguise
    tgt_wrong  = taken && pred_taken && (ent_tgt != target);
    // R2, R6: direction mismatch, or not eligible at all
    mispredict = rs_valid && (!elig || (pred_taken != taken) || tgt_wrong);
    // R3: allocate only on a taken outcome, otherwise train existing entries
    wr_en      = rs_valid && elig && (hit || taken);
    wr_ctr     = hit ? ctr_step(ent_ctr, taken) : CTR_WEAK_TAKEN;
    wr_tgt     = taken ? target : ent_tgt;
  end
endmodule

// File: rtl/btb_predictor.sv
`timescale 1ns/1ps
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 128,
  parameter int PEN_W      = 3,
  parameter int PEN_WIDE   = 4,
  parameter int PEN_NARROW = 5,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int TAG_W     = ADDR_W - IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic [1:0]        rs_class,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic              rs_narrow,
  output logic              rs_mispredict,
  output logic [PEN_W-1:0]  rs_penalty
);
  localparam logic [PEN_W-1:0] PEN_W_CYC = PEN_W'(PEN_WIDE);
  localparam logic [PEN_W-1:0] PEN_N_CYC = PEN_W'(PEN_NARROW);

  // R9: index above bit 1, tag = upper bits plus the halfword bit
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W+1:2];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:IDX_W+2], a[1]};
  endfunction

  logic              unused_lsb;
  logic              lk_valid_e, rs_valid_e;
  logic [TAG_W-1:0]  lk_tag_e, rs_tag_e;
  logic [ADDR_W-1:0] lk_tgt_e, rs_tgt_e;
  logic [1:0]        lk_ctr_e, rs_ctr_e;
  logic              res_hit, res_pred_taken, res_tgt_wrong, wr_en;
  logic [ADDR_W-1:0] wr_tgt;
  logic [1:0]        wr_ctr;

  assign unused_lsb = lk_pc[0] ^ rs_pc[0];

  btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .rd0_idx(idx_of(lk_pc)), .rd0_valid(lk_valid_e), .rd0_tag(lk_tag_e),
    .rd0_tgt(lk_tgt_e), .rd0_ctr(lk_ctr_e),
    .rd1_idx(idx_of(rs_pc)), .rd1_valid(rs_valid_e), .rd1_tag(rs_tag_e),
    .rd1_tgt(rs_tgt_e), .rd1_ctr(rs_ctr_e),
    .wr_en(wr_en), .wr_idx(idx_of(rs_pc)), .wr_tag(tag_of(rs_pc)),
    .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  btb_resolve #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_resolve (
    .rs_valid(rs_valid), .cls(br_class_e'(rs_class)), .taken(rs_taken),
    .target(rs_target), .tag(tag_of(rs_pc)),
    .ent_valid(rs_valid_e), .ent_tag(rs_tag_e), .ent_tgt(rs_tgt_e), .ent_ctr(rs_ctr_e),
    .hit(res_hit), .pred_taken(res_pred_taken), .tgt_wrong(res_tgt_wrong),
    .mispredict(rs_mispredict), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr)
  );

  // R4: fetch-side answer
  always_comb begin
    lk_hit    = lk_valid_e && (lk_tag_e == tag_of(lk_pc));
    lk_taken  = lk_hit && ctr_says_taken(lk_ctr_e);
    lk_target = lk_hit ? lk_tgt_e : '0;
  end

  // R7: penalty by instruction-set mode
  always_comb begin
    if (!rs_mispredict) rs_penalty = '0;
    else                rs_penalty = rs_narrow ? PEN_N_CYC : PEN_W_CYC;
  end
endmodule

// File: rtl/btb_checker.sv
`timescale 1ns/1ps
module btb_checker #(
  parameter int PEN_W      = 3,
  parameter int PEN_NARROW = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_hit,
  input logic             lk_taken,
  input logic             rs_valid,
  input logic [1:0]       rs_class,
  input logic             rs_taken,
  input logic             rs_narrow,
  input logic             rs_mispredict,
  input logic [PEN_W-1:0] rs_penalty,
  input logic             res_hit,
  input logic             wr_en
);
  a_r4_miss_not_taken: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_taken);
  a_r2_pc_write_penalised: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_class == btb_pkg::BR_PC_WRITE) |-> rs_mispredict);
  a_r7_correct_is_free: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_mispredict) |-> (rs_penalty == '0));
  a_r7_narrow_cost: assert property (@(posedge clk) disable iff (rst)
    (rs_mispredict && rs_narrow) |-> (rs_penalty == PEN_W'(PEN_NARROW)));
  a_r3_no_alloc_on_fallthrough: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (rs_taken || res_hit));
  a_r6_taken_miss_flagged: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_taken && !res_hit) |-> rs_mispredict);
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);
endmodule

bind btb_predictor btb_checker #(.PEN_W(PEN_W), .PEN_NARROW(PEN_NARROW)) u_chk (
  .clk(clk), .rst(rst), .lk_hit(lk_hit), .lk_taken(lk_taken),
  .rs_valid(rs_valid), .rs_class(rs_class), .rs_taken(rs_taken),
  .rs_narrow(rs_narrow), .rs_mispredict(rs_mispredict), .rs_penalty(rs_penalty),
  .res_hit(res_hit), .wr_en(wr_en)
);

// File: tb/sim_btb_predictor.sv
`timescale 1ns/1ps
module sim_btb_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic [1:0]  rs_class = '0;
  logic        rs_taken = 1'b0;
  logic [31:0] rs_target = '0;
  logic        rs_narrow = 1'b0;
  logic        rs_mispredict;
  logic [2:0]  rs_penalty;

  always #2 clk = ~clk;

  btb_predictor u0 (.*);

  typedef struct {
    string       req;
    bit          chk_rs;
    bit          e_hit, e_tk;
    logic [31:0] e_tgt;
    bit          e_mis;
    int          e_pen;
  } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;

  // bench model of the buffer
  bit          m_v   [128];
  logic [23:0] m_tag [128];
  logic [31:0] m_tgt [128];
  int          m_ctr [128];

  function automatic int ix(input logic [31:0] a); return int'(a[8:2]); endfunction
  function automatic logic [23:0] tg(input logic [31:0] a); return {a[31:9], a[1]}; endfunction

  task automatic model_clear();
    for (int i = 0; i < 128; i++) m_v[i] = 0;
  endtask

  task automatic step(input logic [31:0] lpc, input bit res, input logic [31:0] rpc,
                      input logic [1:0] cls, input bit tk, input logic [31:0] tgt,
                      input bit nar, input string req);
    item_t it;
    int i, j;
    bit elig, h, pt;
    @(posedge clk); #1;
    lk_pc = lpc; rs_valid = res; rs_pc = rpc; rs_class = cls;
    rs_taken = tk; rs_target = tgt; rs_narrow = nar;
    it.req = req;
    i = ix(lpc);
    it.e_hit = m_v[i] && m_tag[i] == tg(lpc);
    it.e_tk  = it.e_hit && m_ctr[i] >= 2;
    it.e_tgt = it.e_hit ? m_tgt[i] : 32'h0;
    it.chk_rs = res;
    it.e_mis = 0; it.e_pen = 0;
    if (res) begin
      j = ix(rpc);
      elig = (cls != 2'd3);
      h  = elig && m_v[j] && m_tag[j] == tg(rpc);
      pt = h && m_ctr[j] >= 2;
      it.e_mis = !elig || (pt != tk) || (tk && pt && m_tgt[j] != tgt);
      it.e_pen = it.e_mis ? (nar ? 5 : 4) : 0;
      if (elig && (h || tk)) begin
        if (h) m_ctr[j] = tk ? (m_ctr[j] == 3 ? 3 : m_ctr[j] + 1)
                             : (m_ctr[j] == 0 ? 0 : m_ctr[j] - 1);
        else begin m_ctr[j] = 2; m_v[j] = 1; m_tag[j] = tg(rpc); end
        if (tk) m_tgt[j] = tgt;
      end
    end
    q.push_back(it);
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst = 1; rs_valid = 0;
    @(posedge clk); #1; rst = 0;
    model_clear();
  endtask

  // monitor: compare at the falling edge
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (lk_hit !== it.e_hit || lk_taken !== it.e_tk || lk_target !== it.e_tgt) begin
        n_fail++;
        $display("FAIL %s lookup: got hit=%0b tk=%0b tgt=%h exp hit=%0b tk=%0b tgt=%h",
                 it.req, lk_hit, lk_taken, lk_target, it.e_hit, it.e_tk, it.e_tgt);
      end
      if (it.chk_rs) begin
        n_chk++;
        if (rs_mispredict !== it.e_mis || int'(rs_penalty) != it.e_pen) begin
          n_fail++;
          $display("FAIL %s resolve: got mis=%0b pen=%0d exp mis=%0b pen=%0d",
                   it.req, rs_mispredict, rs_penalty, it.e_mis, it.e_pen);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    step(32'h100, 0, 0, 0, 0, 0, 0, "R10_reset_miss");
    // R3 not-taken miss: no alloc
    step(32'h100, 1, 32'h100, 0, 0, 32'h200, 0, "R3_nt_miss");
    step(32'h100, 0, 0, 0, 0, 0, 0, "R3_still_miss");
    // R6 taken miss, allocate weakly taken (R5)
    step(32'h100, 1, 32'h100, 0, 1, 32'h200, 0, "R6_taken_miss");
    step(32'h100, 0, 0, 0, 0, 0, 0, "R4_R5_hit_weak");
    step(32'h100, 1, 32'h100, 0, 1, 32'h200, 0, "R7_correct");
    step(32'h100, 1, 32'h100, 0, 1, 32'h200, 0, "R5_saturate");
    step(32'h100, 1, 32'h100, 0, 0, 32'h200, 0, "R6_pt_not_taken");
    step(32'h100, 1, 32'h100, 0, 0, 32'h200, 0, "R6_pt_not_taken2");
    step(32'h100, 1, 32'h100, 0, 0, 32'h200, 0, "R5_down");
    step(32'h100, 1, 32'h100, 0, 0, 32'h200, 0, "R5_floor");
    step(32'h100, 1, 32'h100, 0, 1, 32'h200, 0, "R6_pnt_taken");
    step(32'h100, 1, 32'h100, 0, 1, 32'h200, 0, "R5_up");
    // R8 target change
    step(32'h100, 1, 32'h100, 0, 1, 32'h240, 0, "R8_new_target");
    step(32'h100, 0, 0, 0, 0, 0, 0, "R8_target_stored");
    // R7 narrow penalty; R9 bit 1 in tag
    step(32'h302, 1, 32'h302, 2, 1, 32'h500, 1, "R7_narrow");
    step(32'h300, 1, 32'h300, 1, 0, 32'h0, 0, "R9_halfword_tag");
    step(32'h302, 0, 0, 0, 0, 0, 0, "R9_kept");
    // R2 PC write: penalised, not allocated
    step(32'h400, 1, 32'h400, 3, 1, 32'h800, 0, "R2_pcwrite_wide");
    step(32'h400, 1, 32'h400, 3, 0, 32'h800, 1, "R2_pcwrite_narrow");
    step(32'h400, 0, 0, 0, 0, 0, 0, "R2_never_alloc");
    // R9 alias replace at 0x100 + 0x200
    step(32'h100, 1, 32'h300 - 32'h200 + 32'h200, 1, 1, 32'h900, 0, "R9_alias_replace");
    step(32'h100, 0, 0, 0, 0, 0, 0, "R9_old_gone");
    // R11 same cycle collision
    step(32'h600, 1, 32'h600, 0, 1, 32'h700, 0, "R11_same_cycle");
    step(32'h600, 0, 0, 0, 0, 0, 0, "R11_after");
    // R10 mid-run reset
    do_reset();
    step(32'h600, 0, 0, 0, 0, 0, 0, "R10_cleared");
    step(32'h302, 0, 0, 0, 0, 0, 0, "R10_cleared2");
    // random mix (R1, R6, R9)
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a, l;
      logic [1:0] c;
      a = 32'h1000 + ($urandom % 4) * 4 + ($urandom % 3) * 32'h200 + ($urandom % 2) * 2;
      l = 32'h1000 + ($urandom % 4) * 4 + ($urandom % 3) * 32'h200 + ($urandom % 2) * 2;
      c = 2'($urandom % 4);
      step(l, ($urandom % 4) != 0, a, c, 1'($urandom % 2),
           32'h8000 + ($urandom % 3) * 16, 1'($urandom % 2), "R1_R6_random");
    end
    @(posedge clk); #1; rs_valid = 0;
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule